// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level table structure held in main memory, one translation at a time. A requester presents the address together with a flag that marks the access as a write. The walker breaks the address into an upper table index, a lower table index and a byte offset within a 4 KB page. It checks the upper index against a programmable table length. It then reads the upper-level entry, and that entry points to the lower-level table, whose entry supplies the page frame. Each step can end the walk early with a fault code.

Memory is reached through a plain request/response word port. A request holds its address until the memory side accepts it, and the response may come any number of cycles later. Software programs the start address of the upper table and its length through a one-cycle register write port. The result appears on a one-cycle done pulse, together with a two-bit fault code and, on success, the physical address.

The controller is a five-state machine with these states:
- IDLE: ready for a request.
- FETCH_OUTER: reading the upper entry.
- FETCH_INNER: reading the lower entry.
- DONE: reporting a good translation.
- FAULT: reporting a failed one.

Its transitions are:
- accept: IDLE to FETCH_OUTER, taken when the upper index is in bound.
- bound_fail: IDLE to FAULT, taken when the upper index is not in bound.
- outer_ok: FETCH_OUTER to FETCH_INNER.
- outer_bad: FETCH_OUTER to FAULT.
- leaf_ok: FETCH_INNER to DONE.
- leaf_bad: FETCH_INNER to FAULT.
- report: DONE or FAULT back to IDLE.

Top module: `two_level_walker`

## Requirements
- R1: The virtual address splits into an upper index in bits 31:22, a lower index in bits 21:12 and a page offset in bits 11:0.
- R2: The first memory read of an in-bound walk goes to the byte address base + 4 × upper index, where base is the programmed table start.
- R3: When the upper index, zero-extended, is not below the programmed length, done rises on the cycle after acceptance with fault code 1. No memory request is made for that walk.
- R4: The second memory read goes to the byte address {upper entry bits 31:12, lower index, 2'b00}.
- R5: In a table entry, bit 0 is the valid flag, bit 1 is the read-only flag, bits 31:12 are the frame number, and bits 11:2 are ignored. A clear valid flag in the upper entry ends the walk with fault code 2 after exactly one read. A clear valid flag in the lower entry ends it with fault code 2 after two reads.
- R6: A write request whose lower entry has the read-only flag set ends with fault code 3. A read request to the same page succeeds. The read-only flag of the upper entry has no effect.
- R7: On success the fault code is 0 and paddr equals {lower entry bits 31:12, virtual address bits 11:0}.
- R8: mem_req_valid and mem_req_addr stay unchanged until mem_req_ready is seen high. A response is taken only after its request was accepted, and any delay before it is tolerated.
- R9: done is high for exactly one cycle per walk. While done is low, fault and paddr are 0. On a faulting walk, paddr is 0.
- R10: req_ready is high only in IDLE. A request presented while a walk is in flight is ignored and starts no memory access.
- R11: After reset, base and length are 0, so every walk ends in a bound fault. A write with cfg_sel = 0 loads base from cfg_wdata. A write with cfg_sel = 1 loads length from cfg_wdata bits 10:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 length |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data (table entry) |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 0 none, 1 bound, 2 invalid, 3 protection |
| paddr | output | 32 | Physical address on success |

## Verification
The bench builds the walker with its default 10/10/12 split and 32-bit physical addresses. It programs a table at byte address 0x40000 with a length of 600. Uniform random upper indices then fall on both sides of the bound, and directed walks hit index 599 and index 600 exactly. Every lower table is one of eight shared tables, densely filled, so random walks often reach all four fault codes and the success path. Random ready gaps and response delays exercise the hold rule of the memory port. Later, the base is moved and the length is raised to 1024 to show that both registers take effect.

// File: rtl/walk_pkg.sv
package walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_OUTER,
        ST_FETCH_INNER,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_BOUND   = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_PROT    = 2'd3
    } walk_fault_e;

    // entry flag positions
    localparam int ENT_VALID_BIT = 0;
    localparam int ENT_RO_BIT    = 1;
    // entries are 4-byte words
    localparam int WORD_SHIFT    = 2;

endpackage

// File: rtl/walk_cfg.sv
module walk_cfg #(
    parameter int PA_W  = 32,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [PA_W-1:0]  cfg_wdata,
    output logic [PA_W-1:0]  base_o,
    output logic [LEN_W-1:0] len_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o <= '0;
            len_o  <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) begin
                len_o <= cfg_wdata[LEN_W-1:0];
            end else begin
                base_o <= cfg_wdata;
            end
        end
    end

endmodule

// File: rtl/walk_addr.sv
module walk_addr
    import walk_pkg::*;
#(
    parameter int OUT_W = 10,
    parameter int IN_W  = 10,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32,
    parameter int LEN_W = OUT_W + 1
) (
    input  logic [PA_W-1:0]       base_i,
    input  logic [LEN_W-1:0]      len_i,
    input  logic [OUT_W-1:0]      outer_idx_i,
    input  logic [IN_W-1:0]       inner_idx_i,
    input  logic [OFF_W-1:0]      offset_i,
    input  logic [PA_W-OFF_W-1:0] frame_i,
    output logic [PA_W-1:0]       outer_addr_o,
    output logic                  in_bound_o,
    output logic [PA_W-1:0]       inner_addr_o,
    output logic [PA_W-1:0]       leaf_pa_o
);

    localparam int SH_W = IN_W + WORD_SHIFT;

    logic [OFF_W-1:0] inner_off;

    generate
        if (SH_W == OFF_W) begin : g_exact
            assign inner_off = {inner_idx_i, {WORD_SHIFT{1'b0}}};
        end else if (SH_W < OFF_W) begin : g_pad
            assign inner_off = {{(OFF_W - SH_W){1'b0}}, inner_idx_i, {WORD_SHIFT{1'b0}}};
        end else begin : g_trunc
            assign inner_off = {inner_idx_i[OFF_W-WORD_SHIFT-1:0], {WORD_SHIFT{1'b0}}};
        end
    endgenerate

    always_comb begin
        outer_addr_o = base_i + ({{(PA_W - OUT_W){1'b0}}, outer_idx_i} << WORD_SHIFT);
        in_bound_o   = LEN_W'(outer_idx_i) < len_i;
        inner_addr_o = {frame_i, inner_off};
        leaf_pa_o    = {frame_i, offset_i};
    end

endmodule

// File: rtl/walk_fsm.sv
module walk_fsm
    import walk_pkg::*;
#(
    parameter int LOW_W = 22,
    parameter int PA_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic [LOW_W-1:0] req_low_i,
    output logic             req_ready_o,
    input  logic             in_bound_i,
    input  logic [PA_W-1:0]  outer_addr_i,
    input  logic [PA_W-1:0]  inner_addr_i,
    input  logic [PA_W-1:0]  leaf_pa_i,
    output logic [LOW_W-1:0] held_low_o,
    output logic             mem_req_valid_o,
    output logic [PA_W-1:0]  mem_req_addr_o,
    input  logic             mem_req_ready_i,
    input  logic             mem_rsp_valid_i,
    input  logic             ent_valid_i,
    input  logic             ent_ro_i,
    output logic             done_o,
    output logic [1:0]       fault_o,
    output logic [PA_W-1:0]  paddr_o
);

    walk_state_e state_q, state_d;
    walk_fault_e code_q;
    logic             issued_q;
    logic             wr_q;
    logic [LOW_W-1:0] low_q;
    logic [PA_W-1:0]  addr_q;
    logic [PA_W-1:0]  pa_q;
    logic             accept;
    logic             rsp_take;

    assign accept   = (state_q == ST_IDLE) && req_valid_i;
    assign rsp_take = issued_q && mem_rsp_valid_i;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i) begin
                    state_d = in_bound_i ? ST_FETCH_OUTER : ST_FAULT;
                end
            end
            ST_FETCH_OUTER: begin
                if (rsp_take) begin
                    state_d = ent_valid_i ? ST_FETCH_INNER : ST_FAULT;
                end
            end
            ST_FETCH_INNER: begin
                if (rsp_take) begin
                    if (!ent_valid_i || (wr_q && ent_ro_i)) begin
                        state_d = ST_FAULT;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued_q <= 1'b0;
            wr_q     <= 1'b0;
            low_q    <= '0;
            addr_q   <= '0;
            pa_q     <= '0;
            code_q   <= FLT_NONE;
        end else begin
            if (accept) begin
                wr_q     <= req_write_i;
                low_q    <= req_low_i;
                addr_q   <= outer_addr_i;
                issued_q <= 1'b0;
                code_q   <= in_bound_i ? FLT_NONE : FLT_BOUND;
            end
            if (mem_req_valid_o && mem_req_ready_i) begin
                issued_q <= 1'b1;
            end
            if (rsp_take) begin
                issued_q <= 1'b0;
                if (state_q == ST_FETCH_OUTER) begin
                    if (!ent_valid_i) begin
                        code_q <= FLT_INVALID;
                    end else begin
                        addr_q <= inner_addr_i;
                    end
                end else begin
                    if (!ent_valid_i) begin
                        code_q <= FLT_INVALID;
                    end else if (wr_q && ent_ro_i) begin
                        code_q <= FLT_PROT;
                    end else begin
                        pa_q <= leaf_pa_i;
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready_o     = (state_q == ST_IDLE);
        mem_req_valid_o = ((state_q == ST_FETCH_OUTER) || (state_q == ST_FETCH_INNER)) && !issued_q;
        mem_req_addr_o  = addr_q;
        done_o          = (state_q == ST_DONE) || (state_q == ST_FAULT);
        fault_o         = (state_q == ST_FAULT) ? code_q : FLT_NONE;
        paddr_o         = (state_q == ST_DONE) ? pa_q : '0;
        held_low_o      = low_q;
    end

endmodule

// File: rtl/two_level_walker.sv
module two_level_walker
    import walk_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OUT_W = 10,
    parameter int IN_W  = 10,
    parameter int PA_W  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [PA_W-1:0] cfg_wdata,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_write,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [PA_W-1:0] mem_rsp_data,
    output logic            done,
    output logic [1:0]      fault,
    output logic [PA_W-1:0] paddr
);

    localparam int OFF_W = VA_W - OUT_W - IN_W;
    localparam int LOW_W = OFF_W + IN_W;
    localparam int LEN_W = OUT_W + 1;
    localparam int FRM_W = PA_W - OFF_W;

    logic [PA_W-1:0]  base_q;
    logic [LEN_W-1:0] len_q;
    logic [LOW_W-1:0] held_low;
    logic [PA_W-1:0]  outer_addr;
    logic [PA_W-1:0]  inner_addr;
    logic [PA_W-1:0]  leaf_pa;
    logic             in_bound;
    logic             unused_rsp_bits;

    // entry bits between the flags and the frame are reserved
    assign unused_rsp_bits = ^mem_rsp_data[OFF_W-1:ENT_RO_BIT+1];

    walk_cfg #(
        .PA_W  (PA_W),
        .LEN_W (LEN_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_o    (base_q),
        .len_o     (len_q)
    );

    walk_addr #(
        .OUT_W (OUT_W),
        .IN_W  (IN_W),
        .OFF_W (OFF_W),
        .PA_W  (PA_W),
        .LEN_W (LEN_W)
    ) u_addr (
        .base_i       (base_q),
        .len_i        (len_q),
        .outer_idx_i  (req_vaddr[VA_W-1 -: OUT_W]),
        .inner_idx_i  (held_low[LOW_W-1 -: IN_W]),
        .offset_i     (held_low[OFF_W-1:0]),
        .frame_i      (mem_rsp_data[PA_W-1 -: FRM_W]),
        .outer_addr_o (outer_addr),
        .in_bound_o   (in_bound),
        .inner_addr_o (inner_addr),
        .leaf_pa_o    (leaf_pa)
    );

    walk_fsm #(
        .LOW_W (LOW_W),
        .PA_W  (PA_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid_i     (req_valid),
        .req_write_i     (req_write),
        .req_low_i       (req_vaddr[LOW_W-1:0]),
        .req_ready_o     (req_ready),
        .in_bound_i      (in_bound),
        .outer_addr_i    (outer_addr),
        .inner_addr_i    (inner_addr),
        .leaf_pa_i       (leaf_pa),
        .held_low_o      (held_low),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_addr_o  (mem_req_addr),
        .mem_req_ready_i (mem_req_ready),
        .mem_rsp_valid_i (mem_rsp_valid),
        .ent_valid_i     (mem_rsp_data[ENT_VALID_BIT]),
        .ent_ro_i        (mem_rsp_data[ENT_RO_BIT]),
        .done_o          (done),
        .fault_o         (fault),
        .paddr_o         (paddr)
    );

endmodule

// File: rtl/walk_checker.sv
module walk_checker #(
    parameter int OUT_W = 10,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32,
    parameter int LEN_W = OUT_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [OUT_W-1:0] req_outer,
    input logic [OFF_W-1:0] req_off,
    input logic [LEN_W-1:0] len_q,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             done,
    input logic [1:0]       fault,
    input logic [OFF_W-1:0] pa_off
);

    logic [OFF_W-1:0] off_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_seen <= '0;
        end else if (req_valid && req_ready) begin
            off_seen <= req_off;
        end
    end

    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_quiet_code: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (fault == 2'd0));

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r3_bound_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (LEN_W'(req_outer) >= len_q))
        |=> (done && (fault == 2'd1) && !mem_req_valid));

    a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (fault == 2'd0)) |-> (pa_off == off_seen));

endmodule

bind two_level_walker walk_checker #(
    .OUT_W (OUT_W),
    .OFF_W (OFF_W),
    .PA_W  (PA_W),
    .LEN_W (LEN_W)
) u_walk_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_outer     (req_vaddr[VA_W-1 -: OUT_W]),
    .req_off       (req_vaddr[OFF_W-1:0]),
    .len_q         (len_q),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .fault         (fault),
    .pa_off        (paddr[OFF_W-1:0])
);

// File: tb/test_two_level_walker.sv
`timescale 1ns/1ps
module test_two_level_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [1:0]  fault;
    logic [31:0] paddr;

    always #4 clk = ~clk;

    two_level_walker i_two_level_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_sel       (cfg_sel),
        .cfg_wdata     (cfg_wdata),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .fault         (fault),
        .paddr         (paddr)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [31:0] mem_m [logic [31:0]];
    logic [31:0] base_m = '0;
    logic [10:0] len_m = '0;

    int          rdy_pct = 100;
    int          max_dly = 0;
    int          acc_n = 0;
    logic [31:0] acc_addr [4];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem_m.exists(a)) return mem_m[a];
        return 32'h0;
    endfunction

    function automatic logic [31:0] mkva(input int oi, input int ii, input int off);
        return {oi[9:0], ii[9:0], off[11:0]};
    endfunction

    function automatic logic [31:0] mkent(input logic [19:0] fr, input bit ro, input bit v);
        logic [9:0] junk;
        junk = 10'($urandom);
        return {fr, junk, ro, v};
    endfunction

    // expected walk computed from the requirements
    function automatic void model(input logic [31:0] va, input bit wr,
                                  output logic [1:0] f, output logic [31:0] pa,
                                  output int n, output logic [31:0] a0, output logic [31:0] a1);
        logic [9:0]  oi;
        logic [9:0]  ii;
        logic [31:0] e0;
        logic [31:0] e1;
        oi = va[31:22];
        ii = va[21:12];
        n = 0; pa = 0; a0 = 0; a1 = 0; f = 0;
        if ({1'b0, oi} >= len_m) begin
            f = 2'd1;
            return;
        end
        a0 = base_m + (32'(oi) << 2);
        n = 1;
        e0 = rd(a0);
        if (!e0[0]) begin
            f = 2'd2;
            return;
        end
        a1 = {e0[31:12], ii, 2'b00};
        n = 2;
        e1 = rd(a1);
        if (!e1[0]) f = 2'd2;
        else if (wr && e1[1]) f = 2'd3;
        else pa = {e1[31:12], va[11:0]};
    endfunction

    // memory model: random ready, random response delay
    initial begin
        bit          pend;
        int          cnt;
        logic [31:0] raddr;
        pend = 0; cnt = 0; raddr = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = $urandom;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(raddr);
                    pend = 0;
                end else begin
                    cnt--;
                end
            end
            mem_req_ready = (($urandom % 100) < rdy_pct);
            if (mem_req_valid && mem_req_ready && !pend) begin
                if (acc_n < 4) acc_addr[acc_n] = mem_req_addr;
                acc_n++;
                raddr = mem_req_addr;
                pend = 1;
                cnt = (max_dly == 0) ? 0 : int'($urandom % (max_dly + 1));
            end
        end
    end

    task automatic cfg_write(input bit sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) len_m = d[10:0];
        else base_m = d;
    endtask

    task automatic run_walk(input logic [31:0] va, input bit wr, input bit poke, input string tag);
        logic [1:0]  ef;
        logic [31:0] epa;
        int          en;
        logic [31:0] ea0;
        logic [31:0] ea1;
        int          waited;
        bit          extra_done;
        model(va, wr, ef, epa, en, ea0, ea1);
        @(negedge clk);
        acc_n = 0;
        chk(req_ready == 1'b1, {"R10 idle ready ", tag}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = $urandom; req_write = $urandom;
        waited = 0;
        while (!done && waited < 3000) begin
            if (poke && waited == 2) begin
                chk(req_ready == 1'b0, {"R10 busy not ready ", tag}, 32'(req_ready), 32'd0);
                req_valid = 1'b1; req_vaddr = ~va; req_write = 1'b0;
            end
            if (poke && waited == 3) req_valid = 1'b0;
            @(negedge clk);
            waited++;
        end
        req_valid = 1'b0;
        chk(done == 1'b1, {"R8 walk completes ", tag}, 32'(done), 32'd1);
        chk(fault == ef, {"R5 R6 fault code ", tag}, 32'(fault), 32'(ef));
        if (ef == 2'd0) chk(paddr == epa, {"R7 paddr ", tag}, paddr, epa);
        else chk(paddr == 32'h0, {"R9 paddr zero on fault ", tag}, paddr, 32'h0);
        chk(acc_n == en, {"R3 R5 read count ", tag}, 32'(acc_n), 32'(en));
        if (en >= 1) chk(acc_addr[0] == ea0, {"R2 outer address ", tag}, acc_addr[0], ea0);
        if (en >= 2) chk(acc_addr[1] == ea1, {"R1 R4 inner address ", tag}, acc_addr[1], ea1);
        if (ef == 2'd1) chk(waited == 0, {"R3 bound latency ", tag}, 32'(waited), 32'd0);
        @(negedge clk);
        chk(done == 1'b0, {"R9 done one cycle ", tag}, 32'(done), 32'd0);
        chk(fault == 2'd0, {"R9 quiet fault ", tag}, 32'(fault), 32'd0);
        if (poke) begin
            extra_done = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done) extra_done = 1;
            end
            chk(acc_n == en, {"R10 ignored request no access ", tag}, 32'(acc_n), 32'(en));
            chk(!extra_done, {"R10 ignored request no done ", tag}, 32'(extra_done), 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(req_ready == 1'b1, "R11 reset ready", 32'(req_ready), 32'd1);
        chk(done == 1'b0, "R11 reset done", 32'(done), 32'd0);
        chk(mem_req_valid == 1'b0, "R11 reset mem idle", 32'(mem_req_valid), 32'd0);
        chk(fault == 2'd0, "R11 reset fault", 32'(fault), 32'd0);
        chk(paddr == 32'h0, "R11 reset paddr", paddr, 32'h0);
        // R11 length 0 after reset: bound fault even for index 0
        run_walk(mkva(0, 0, 0), 1'b0, 1'b0, "R11 reset length zero");

        // fill tables: upper at 0x40000, eight shared lower tables at frames 0x100..0x107
        for (int i = 0; i < 600; i++) begin
            mem_m[32'h0004_0000 + 32'(i) * 4] =
                mkent(20'h00100 + 20'(i % 8), 1'($urandom), (($urandom % 100) < 80));
        end
        for (int t = 0; t < 8; t++) begin
            for (int j = 0; j < 1024; j++) begin
                mem_m[{20'h00100 + 20'(t), 10'(j), 2'b00}] =
                    mkent(20'($urandom), 1'($urandom), (($urandom % 100) < 85));
            end
        end
        // directed entries
        mem_m[32'h0004_0000 + 5 * 4] = mkent(20'h00300, 1'b0, 1'b0);
        mem_m[32'h0004_0000 + 6 * 4] = mkent(20'h00200, 1'b1, 1'b1);
        mem_m[32'h0004_0000 + 599 * 4] = mkent(20'h00200, 1'b0, 1'b1);
        mem_m[{20'h00200, 10'd3, 2'b00}] = mkent(20'hABCDE, 1'b1, 1'b1);
        mem_m[{20'h00200, 10'd4, 2'b00}] = mkent(20'h55555, 1'b0, 1'b0);
        mem_m[{20'h00200, 10'd7, 2'b00}] = mkent(20'h12345, 1'b0, 1'b1);

        cfg_write(1'b0, 32'h0004_0000);
        cfg_write(1'b1, 32'hFFFF_F258); // low 11 bits = 600

        rdy_pct = 100; max_dly = 0;
        run_walk(mkva(599, 7, 12'h9A5), 1'b1, 1'b0, "R3 last in-bound index");
        run_walk(mkva(600, 7, 12'h001), 1'b0, 1'b0, "R3 first out-of-bound index");
        run_walk(mkva(1023, 0, 0), 1'b1, 1'b0, "R3 top index");
        run_walk(mkva(5, 3, 12'h123), 1'b0, 1'b0, "R5 outer invalid");
        run_walk(mkva(6, 4, 12'h456), 1'b0, 1'b0, "R5 inner invalid");
        run_walk(mkva(6, 3, 12'h777), 1'b1, 1'b0, "R6 write to read-only");
        run_walk(mkva(6, 3, 12'hFFF), 1'b0, 1'b0, "R6 read of read-only");
        run_walk(mkva(6, 7, 12'h000), 1'b1, 1'b0, "R6 outer ro ignored");

        rdy_pct = 30; max_dly = 20;
        run_walk(mkva(6, 7, 12'h3C3), 1'b0, 1'b1, "R10 busy request");
        run_walk(mkva(6, 3, 12'h811), 1'b0, 1'b0, "R8 slow memory");

        for (int r = 0; r < 300; r++) begin
            rdy_pct = 20 + int'($urandom % 81);
            max_dly = int'($urandom % 6);
            run_walk(mkva(int'($urandom % 1024), int'($urandom % 1024), int'($urandom % 4096)),
                     1'($urandom), 1'b0, "random");
        end

        // R11 base register moves the upper table
        rdy_pct = 100; max_dly = 0;
        cfg_write(1'b0, 32'h0008_0000);
        run_walk(mkva(6, 7, 12'h010), 1'b0, 1'b0, "R11 moved base");
        cfg_write(1'b0, 32'h0004_0000);
        cfg_write(1'b1, 32'd1024);
        run_walk(mkva(1023, 1, 12'h020), 1'b0, 1'b0, "R11 full length");
        run_walk(mkva(6, 7, 12'h030), 1'b0, 1'b0, "R11 restored base");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual %h expected %h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule